// File: doc/BRIEF.md
# GPIO Event Status Register with Race-Free Acknowledge

This block watches a bank of general-purpose input pins and records, per pin, when a chosen trigger condition occurs. Every pin has its own 3-bit trigger code selecting no trigger, a rising edge, a falling edge, either edge, a low level or a high level. The recorded events sit in a status register, one bit per pin. Software changes that register through two separate write paths: one sets the bits written as 1 and the other clears them. A single interrupt line reports whether any status bit whose mask bit is 1 is set.

The central property is that a write never blocks hardware events. The next status is built bit by bit: the old value, minus the clear mask, plus the set mask, plus the events detected in that cycle. An event that lands in the same cycle as a set or clear write, to the same bit or to any other bit, is therefore always recorded. Level triggers set their bit again on every cycle while the level holds, so a clear issued while the level persists cannot lose the event.

Each pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised value with its value one cycle earlier. Set and clear are plain single-cycle strobes with data. They take effect on every cycle their enable is high, and there is no back-pressure.

Top module: `gpio_evt_status`

## Requirements
- R1: During reset, and on the first sample after reset, `status_o` is all zeros and `irq_o` is 0.
- R2: When the trigger code is 1 (rising), a 0-to-1 change on a pin sets its status bit at the third rising clock edge after the change, counting the edge that first samples the new value.
- R3: When the trigger code is 2 (falling), a 1-to-0 change sets the status bit with the same latency as R2.
- R4: When the trigger code is 3 (any edge), both kinds of change set the status bit.
- R5: When the trigger code is 4 (low level), or 5 (high level), the bit is set on every cycle while the synchronised pin is at that level. A clear in such a cycle leaves the bit set.
- R6: Trigger codes 0, 6 and 7 never set the status bit, whatever the pin does.
- R7: A cycle with `set_we_i` high sets every status bit whose bit in `set_data_i` is 1. Bits written 0 keep their value, and with no write and no event the status holds.
- R8: A cycle with `clr_we_i` high clears every status bit whose bit in `clr_data_i` is 1, unless R9 or R10 applies to that bit.
- R9: An event detected in the same cycle as a set or clear write, to the same bit or to any other bit, is still recorded in the status register.
- R10: If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R11: `irq_o` is registered. It is 1 exactly one clock after a cycle in which `status_o & irq_mask_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous GPIO inputs |
| trig_cfg_i | input | 96 | Trigger code per pin, pin n in bits [3n+2:3n] |
| irq_mask_i | input | 32 | Interrupt enable per status bit |
| set_we_i | input | 1 | Write-one-to-set strobe |
| set_data_i | input | 32 | Bits to set |
| clr_we_i | input | 1 | Write-one-to-clear strobe |
| clr_data_i | input | 32 | Bits to clear |
| status_o | output | 32 | Status register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Several behaviours are checked on every cycle by assertions. A detected event must show in the status on the next cycle. A set must land, and a clear with no competing set or event must land. The register must hold with no activity. Disabled codes must produce no event, an active level must always produce one, and the interrupt must stay low after an all-zero status. Some behaviours can only be shown by the bench scenarios. These are the exact three-edge latency from a pin change to the status bit and the coincidence cases where an edge on one pin meets an all-ones clear. Level retriggering after a clear, and the masked interrupt over long random traffic, are also left to the scenarios, which compare against a model built from the requirements.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned TRIG_W = 3;
  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_BOTH = 3'd3,
    TRIG_LOW  = 3'd4,
    TRIG_HIGH = 3'd5
  } trig_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= raw_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[STAGES-1];

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_i,
  input  logic              prev_i,
  input  logic [TRIG_W-1:0] cfg_i,
  output logic              evt_o
);
  always_comb begin
    unique case (cfg_i)
      TRIG_RISE: evt_o = cur_i & ~prev_i;
      TRIG_FALL: evt_o = ~cur_i & prev_i;
      TRIG_BOTH: evt_o = cur_i ^ prev_i;
      TRIG_LOW:  evt_o = ~cur_i;
      TRIG_HIGH: evt_o = cur_i;
      default:   evt_o = 1'b0;
    endcase
  end

  // R6: codes 0, 6, 7 never raise an event
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i == 3'd0 || cfg_i > 3'd5) |-> !evt_o);

  // R5: an active level always raises an event
  p_level_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_i == 3'd5 && cur_i) || (cfg_i == 3'd4 && !cur_i)) |-> evt_o);
endmodule

// File: rtl/gpio_evt_merge.sv
module gpio_evt_merge #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt_i,
  input  logic             set_we_i,
  input  logic [WIDTH-1:0] set_data_i,
  input  logic             clr_we_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] status_q, set_eff, clr_eff;

  assign set_eff = set_we_i ? set_data_i : '0;
  assign clr_eff = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | set_eff | evt_i;

  assign status_o = status_q;

  // R9: every event of a cycle is present in the next status
  p_event_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R10: written set bits are present next cycle, clear or not
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((status_q & $past(set_data_i)) == $past(set_data_i)));

  // R8: uncontested clear bits are zero next cycle
  p_clear_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((status_q & $past(clr_data_i & ~set_eff & ~evt_i)) == '0));

  // R7: no write and no event keeps the status
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we_i && !clr_we_i && evt_i == '0) |=> (status_q == $past(status_q)));
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
  import gpio_evt_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CFG_W      = NUM_PINS * TRIG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [CFG_W-1:0]    trig_cfg_i,
  input  logic [NUM_PINS-1:0] irq_mask_i,
  input  logic                set_we_i,
  input  logic [NUM_PINS-1:0] set_data_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_data_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] cur, prev, evt, status;
  logic                irq_q;

  gpio_evt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_evt_detect det_i (
        .clk(clk), .rst_n(rst_n), .cur_i(cur[i]), .prev_i(prev[i]),
        .cfg_i(trig_cfg_i[i*TRIG_W +: TRIG_W]), .evt_o(evt[i])
      );
    end
  endgenerate

  gpio_evt_merge #(.WIDTH(NUM_PINS)) merge_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .set_we_i(set_we_i), .set_data_i(set_data_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .status_o(status)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & irq_mask_i);

  assign status_o = status;
  assign irq_o    = irq_q;

  // R11: an all-zero status is followed by a low interrupt
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> !irq_o);
endmodule

// File: tb/gpio_evt_status_tb.sv
module gpio_evt_status_tb_top;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin = '0, mask = '0, sdat = '0, cdat = '0;
  logic [3*N-1:0] cfg = '0;
  logic swe = 1'b0, cwe = 1'b0;
  logic [N-1:0] status;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_pv = '0, m_st = '0;
  logic m_irq = 1'b0;

  always #5 clk = ~clk;

  gpio_evt_status dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .trig_cfg_i(cfg), .irq_mask_i(mask),
    .set_we_i(swe), .set_data_i(sdat), .clr_we_i(cwe), .clr_data_i(cdat),
    .status_o(status), .irq_o(irq)
  );

  function automatic logic ev_f(logic c, logic p, logic [2:0] k);
    case (k)
      3'd1: return c & ~p;
      3'd2: return ~c & p;
      3'd3: return c ^ p;
      3'd4: return ~c;
      3'd5: return c;
      default: return 1'b0;
    endcase
  endfunction

  // Requirement-level model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_pv = '0; m_st = '0; m_irq = 1'b0;
    end else begin
      logic [N-1:0] ev;
      for (int i = 0; i < N; i++) ev[i] = ev_f(m_s2[i], m_pv[i], cfg[3*i +: 3]);
      m_irq = |(m_st & mask);
      m_st  = (m_st & ~(cwe ? cdat : '0)) | (swe ? sdat : '0) | ev;
      m_pv = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk(tag, status, m_st);
    chk(tag, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) begin
      swe = 0; cwe = 0;
      tick(); chk_model(tag);
    end
  endtask

  task automatic set_cfg(int p, logic [2:0] k); cfg[3*p +: 3] = k; endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 reset status", status, '0);
    chk("R1 reset irq", {31'd0, irq}, '0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", status, '0);

    // R2: rising latency, bit set at third edge
    set_cfg(0, 3'd1); set_cfg(1, 3'd2); set_cfg(2, 3'd3);
    pin[1] = 1'b1; pin[2] = 1'b1;
    idle(6, "R2 prep");
    cdat = '1; cwe = 1; tick(); cwe = 0;
    idle(2, "R2 cleared");
    pin[0] = 1'b1;
    tick(); chk("R2 edge1", status[0], 1'b0);
    tick(); chk("R2 edge2", status[0], 1'b0);
    tick(); chk("R2 edge3", status[0], 1'b1);
    idle(3, "R2");
    // R3 falling, R4 any edge
    pin[1] = 1'b0; idle(4, "R3");
    chk("R3 fall set", status[1], 1'b1);
    cdat = '1; cwe = 1; tick(); cwe = 0;
    pin[2] = 1'b0; idle(4, "R4 fall");
    chk("R4 fall set", status[2], 1'b1);
    cdat = 32'h4; cwe = 1; tick(); cwe = 0;
    pin[2] = 1'b1; idle(4, "R4 rise");
    chk("R4 rise set", status[2], 1'b1);

    // R5 level retrigger across clear
    cdat = '1; cwe = 1; tick(); cwe = 0;
    set_cfg(4, 3'd5); pin[4] = 1'b1; set_cfg(5, 3'd4);
    idle(4, "R5");
    cdat = 32'h30; cwe = 1; tick(); cwe = 0;
    chk("R5 level survives clear", status & 32'h30, 32'h30);
    set_cfg(4, 3'd0); set_cfg(5, 3'd0);
    cdat = '1; cwe = 1; tick(); cwe = 0; idle(2, "R5 off");

    // R6 disabled codes ignore toggles
    set_cfg(8, 3'd0); set_cfg(9, 3'd6); set_cfg(10, 3'd7);
    for (int k = 0; k < 8; k++) begin pin[10:8] = ~pin[10:8]; tick(); end
    idle(4, "R6");
    chk("R6 disabled no status", status[10:8], 3'b000);

    // R7 set, R8 clear
    sdat = 32'hA500_00C0; swe = 1; tick(); swe = 0;
    chk("R7 set bits", status & 32'hA500_00C0, 32'hA500_00C0);
    cdat = 32'h8000_0040; cwe = 1; tick(); cwe = 0;
    chk("R8 clear bits", status & 32'hA500_00C0, 32'h2500_0080);
    cdat = '1; cwe = 1; tick(); cwe = 0;

    // R9 edge on pin3 meets an all-ones clear in the same cycle
    sdat = 32'h80; swe = 1; tick(); swe = 0;
    set_cfg(3, 3'd1); pin[3] = 1'b1;
    tick(); tick();
    cdat = '1; cwe = 1; tick(); cwe = 0;
    chk("R9 edge kept under clear", status, 32'h0000_0008);
    // R9 edge meets a set of another bit
    cdat = '1; cwe = 1; tick(); cwe = 0;
    set_cfg(3, 3'd2); pin[3] = 1'b0;
    tick(); tick();
    sdat = 32'h1; swe = 1; tick(); swe = 0;
    chk("R9 edge kept under set", status, 32'h0000_0009);

    // R10 set and clear same bit
    cdat = '1; cwe = 1; tick(); cwe = 0;
    sdat = 32'h0001_0000; cdat = 32'h0001_0000; swe = 1; cwe = 1; tick(); swe = 0; cwe = 0;
    chk("R10 set wins", status, 32'h0001_0000);

    // R11 irq registered and masked
    mask = 32'h0001_0000; tick();
    chk("R11 irq one cycle later", {31'd0, irq}, 32'd1);
    mask = 32'h0000_0001; tick(); tick();
    chk("R11 masked low", {31'd0, irq}, 32'd0);

    // Random traffic against the model (R2..R11)
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(15) == 0) cfg[$urandom_range(3*N-1)] ^= 1'b1;
      if ($urandom_range(3) == 0) pin[$urandom_range(N-1)] ^= 1'b1;
      if ($urandom_range(31) == 0) mask = $urandom;
      swe = ($urandom_range(7) == 0); sdat = $urandom & $urandom;
      cwe = ($urandom_range(3) == 0); cdat = $urandom;
      tick(); chk_model("R9 random model");
    end
    swe = 0; cwe = 0;
    idle(4, "R11 random tail");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule